// File: doc/BRIEF.md
# Sub-Addressed Control Register Bank with Frame-Synchronous Latching

This block is the register file behind a write-only two-wire serial slave. A byte-level front end hands it three kinds of event: a start strobe, a byte strobe with an 8-bit byte, and a stop strobe. The first byte after a start must equal the block's fixed 7-bit device address followed by a write direction bit of 0. The second byte is a sub-address. Every byte after that is data.

The sub-address carries a 5-bit register index in bits [4:0] and a mode bit in bit 7. With the mode bit clear, the index steps up by one after each data byte. With it set, every data byte goes to the same register. Twenty-six registers exist, indices 0 to 25. Any write aimed at a higher index is dropped.

Registers 0 to 3 are double-buffered. A write to one of them lands in shadow storage, and the outputs take the shadow contents only on the rising edge of a vertical sync input. This input is synchronised to the clock. Registers 4 to 25 drive their outputs straight after each write. All register contents are visible at once on a flat parallel bus.

Top module: `subaddr_regbank`

## Requirements
- R1: After reset, every register output and every shadow register holds zero. Register i appears on `regs_o[i*8 +: 8]`.
- R2: The first byte after a start is compared with {DEV_ADDR, 1'b0}. If it differs, including the case where only the direction bit (bit 0) is set, no byte of that transaction writes anything until the next start.
- R3: In the byte after a matching address, bits [4:0] give the register index and bit 7 gives the mode. Bits 6:5 have no effect.
- R4: With sub-address bit 7 equal to 0, data byte k (counted from 0) of the transaction is written to index + k.
- R5: With sub-address bit 7 equal to 1, every data byte is written to the index. The register ends up holding the last byte of the transaction.
- R6: A write to an index of 26 or more is discarded. An auto-increment run that passes 25 writes nothing more and does not wrap around to low indices.
- R7: A write to a register in the range 4 to 25 shows on its output one clock after the byte strobe is accepted. Outputs of these registers change only after an accepted byte.
- R8: A write to a register in the range 0 to 3 does not change any output until a vertical pulse. On the pulse, all four outputs take their most recent written values in the same cycle.
- R9: The vertical input passes through a two-stage synchroniser. A rising edge on it updates the latched outputs within 3 clocks. An input held high causes only one update, so writes made while it stays high remain shadowed until the next rising edge.
- R10: A start or a stop restarts byte counting. A transaction that ends after its sub-address writes nothing. Bytes that arrive after a stop and before the next start are ignored. A byte strobe in the same cycle as a start or a stop is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start condition strobe from the byte front end |
| byte_valid_i | input | 1 | One-cycle strobe: byte_i holds a received byte |
| byte_i | input | 8 | Received byte |
| stop_i | input | 1 | Stop condition strobe |
| vpulse_i | input | 1 | Vertical sync pulse, asynchronous |
| regs_o | output | 208 | All 26 register outputs, register i in bits [i*8 +: 8] |

## Verification
The bench sweeps every sub-address index from 0 to 31 in both modes and writes three bytes each time. This covers runs that start in the latched group, cross from register 3 into register 4, and pass index 25. A design that wrapped the index would corrupt low registers, and one that let index 26 or above through would alias some other register. Several writes to latched registers before one pulse check that the outputs jump straight to the newest value. A vertical input held high checks that the edge detector fires only once. A byte that shares a cycle with a start checks that it cannot be taken as the device address. A wrong read-direction address byte checks the match, and stray bytes after a stop check that counting restarts.

// File: rtl/subaddr_regbank_pkg.sv
package subaddr_regbank_pkg;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_ADDR = 2'd1,
        PS_SUB  = 2'd2,
        PS_DATA = 2'd3
    } parse_state_e;

endpackage

// File: rtl/sr_vsync.sv
module sr_vsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } vs_state_t;

    vs_state_t vs_d, vs_q;

    always_comb begin
        vs_d      = vs_q;
        vs_d.sync = {vs_q.sync[STAGES-2:0], async_i};
        vs_d.prev = vs_q.sync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vs_q <= '0;
        else        vs_q <= vs_d;
    end

    assign rise_o = vs_q.sync[STAGES-1] & ~vs_q.prev;
endmodule

// File: rtl/sr_parser.sv
module sr_parser
    import subaddr_regbank_pkg::*;
#(
    parameter int         DW       = 8,
    parameter int         IDX_W    = 5,
    parameter int         NUM_REGS = 26,
    parameter logic [6:0] DEV_ADDR = 7'h2C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             stop_i,
    input  logic             byte_valid_i,
    input  logic [DW-1:0]    byte_i,
    output logic             wr_en_o,
    output logic [IDX_W-1:0] wr_idx_o,
    output logic [DW-1:0]    wr_data_o
);
    localparam int PTR_W    = IDX_W + 1;
    localparam int MODE_BIT = DW - 1;
    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(NUM_REGS);
    localparam logic [DW-1:0]    ADDR_WR = {DEV_ADDR, 1'b0};

    typedef struct packed {
        parse_state_e     st;
        logic [PTR_W-1:0] ptr;
        logic             fixed;
    } ps_state_t;

    ps_state_t ps_d, ps_q;
    logic      in_range;

    assign in_range = (ps_q.ptr < PTR_END);

    always_comb begin
        ps_d      = ps_q;
        wr_en_o   = 1'b0;
        wr_idx_o  = ps_q.ptr[IDX_W-1:0];
        wr_data_o = byte_i;
        if (start_i) begin
            ps_d.st = PS_ADDR;
        end else if (stop_i) begin
            ps_d.st = PS_IDLE;
        end else if (byte_valid_i) begin
            case (ps_q.st)
                PS_IDLE: ps_d.st = PS_IDLE;
                PS_ADDR: ps_d.st = (byte_i == ADDR_WR) ? PS_SUB : PS_IDLE;
                PS_SUB: begin
                    ps_d.ptr   = {1'b0, byte_i[IDX_W-1:0]};
                    ps_d.fixed = byte_i[MODE_BIT];
                    ps_d.st    = PS_DATA;
                end
                PS_DATA: begin
                    if (in_range) begin
                        wr_en_o = 1'b1;
                        if (!ps_q.fixed) ps_d.ptr = ps_q.ptr + 1'b1;
                    end
                end
                default: ps_d.st = PS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ps_q <= '{st: PS_IDLE, ptr: '0, fixed: 1'b0};
        else        ps_q <= ps_d;
    end
endmodule

// File: rtl/sr_store.sv
module sr_store #(
    parameter int DW          = 8,
    parameter int IDX_W       = 5,
    parameter int NUM_REGS    = 26,
    parameter int NUM_LATCHED = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en_i,
    input  logic [IDX_W-1:0]             wr_idx_i,
    input  logic [DW-1:0]                wr_data_i,
    input  logic                         vs_rise_i,
    output logic [NUM_REGS-1:0][DW-1:0]  live_o
);
    typedef struct packed {
        logic [NUM_REGS-1:0][DW-1:0]    live;
        logic [NUM_LATCHED-1:0][DW-1:0] shadow;
    } st_state_t;

    st_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (vs_rise_i) begin
            for (int i = 0; i < NUM_LATCHED; i++) st_d.live[i] = st_q.shadow[i];
        end
        if (wr_en_i) begin
            for (int i = 0; i < NUM_LATCHED; i++)
                if (wr_idx_i == IDX_W'(i)) st_d.shadow[i] = wr_data_i;
            for (int i = NUM_LATCHED; i < NUM_REGS; i++)
                if (wr_idx_i == IDX_W'(i)) st_d.live[i] = wr_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live_o = st_q.live;
endmodule

// File: rtl/subaddr_regbank.sv
module subaddr_regbank #(
    parameter int         DW          = 8,
    parameter int         IDX_W       = 5,
    parameter int         NUM_REGS    = 26,
    parameter int         NUM_LATCHED = 4,
    parameter int         SYNC_STAGES = 2,
    parameter logic [6:0] DEV_ADDR    = 7'h2C
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start_i,
    input  logic                   byte_valid_i,
    input  logic [DW-1:0]          byte_i,
    input  logic                   stop_i,
    input  logic                   vpulse_i,
    output logic [NUM_REGS*DW-1:0] regs_o
);
    logic                        vs_rise;
    logic                        wr_en;
    logic [IDX_W-1:0]            wr_idx;
    logic [DW-1:0]               wr_data;
    logic [NUM_REGS-1:0][DW-1:0] live;

    sr_vsync #(.STAGES(SYNC_STAGES)) u_vsync (
        .clk(clk), .rst_n(rst_n), .async_i(vpulse_i), .rise_o(vs_rise)
    );

    sr_parser #(
        .DW(DW), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS), .DEV_ADDR(DEV_ADDR)
    ) u_parser (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
        .byte_valid_i(byte_valid_i), .byte_i(byte_i),
        .wr_en_o(wr_en), .wr_idx_o(wr_idx), .wr_data_o(wr_data)
    );

    sr_store #(
        .DW(DW), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS), .NUM_LATCHED(NUM_LATCHED)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
        .wr_data_i(wr_data), .vs_rise_i(vs_rise), .live_o(live)
    );

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_out
        assign regs_o[g*DW +: DW] = live[g];
    end
endmodule

// File: rtl/subaddr_regbank_chk.sv
module subaddr_regbank_chk #(
    parameter int DW          = 8,
    parameter int IDX_W       = 5,
    parameter int NUM_REGS    = 26,
    parameter int NUM_LATCHED = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start_i,
    input logic                   stop_i,
    input logic                   byte_valid_i,
    input logic [NUM_REGS*DW-1:0] regs_o,
    input logic                   vs_rise,
    input logic                   wr_en,
    input logic [IDX_W-1:0]       wr_idx
);
    localparam int LAT_W = NUM_LATCHED * DW;

    assert_latched_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_rise |=> $stable(regs_o[LAT_W-1:0]));

    assert_live_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid_i |=> $stable(regs_o[NUM_REGS*DW-1:LAT_W]));

    assert_write_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (byte_valid_i && !start_i && !stop_i));

    assert_index_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (wr_idx < IDX_W'(NUM_REGS)));
endmodule

bind subaddr_regbank subaddr_regbank_chk #(
    .DW(DW), .IDX_W(IDX_W), .NUM_REGS(NUM_REGS), .NUM_LATCHED(NUM_LATCHED)
) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .stop_i(stop_i),
    .byte_valid_i(byte_valid_i), .regs_o(regs_o), .vs_rise(vs_rise),
    .wr_en(wr_en), .wr_idx(wr_idx)
);

// File: tb/subaddr_regbank_bench.sv
module subaddr_regbank_bench;
    localparam int NREG = 26;
    localparam int NLAT = 4;
    localparam logic [7:0] ADDR_WR = {7'h2C, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, byte_valid_i = 1'b0, stop_i = 1'b0, vpulse_i = 1'b0;
    logic [7:0] byte_i = '0;
    logic [NREG*8-1:0] regs_o;

    int checks = 0;
    int fails = 0;
    logic [7:0] exp_out [NREG];
    logic [7:0] exp_sh  [NLAT];

    always #10 clk = ~clk;

    subaddr_regbank u_subaddr_regbank (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .byte_valid_i(byte_valid_i),
        .byte_i(byte_i), .stop_i(stop_i), .vpulse_i(vpulse_i), .regs_o(regs_o)
    );

    task automatic check_reg(input int i, input logic [7:0] e, input string tag);
        checks++;
        if (regs_o[i*8 +: 8] !== e) begin
            fails++;
            $display("FAIL %s reg %0d actual %02h expected %02h", tag, i, regs_o[i*8 +: 8], e);
        end
    endtask

    task automatic check_all(input string tag);
        for (int i = 0; i < NREG; i++) check_reg(i, exp_out[i], tag);
    endtask

    task automatic do_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    task automatic do_stop();
        @(negedge clk); stop_i = 1'b1;
        @(negedge clk); stop_i = 1'b0;
    endtask

    task automatic do_byte(input logic [7:0] b);
        @(negedge clk); byte_valid_i = 1'b1; byte_i = b;
        @(negedge clk); byte_valid_i = 1'b0;
    endtask

    task automatic model_write(input int idx, input logic [7:0] d);
        if (idx < NLAT) exp_sh[idx] = d;
        else if (idx < NREG) exp_out[idx] = d;
    endtask

    task automatic do_vpulse();
        @(negedge clk); vpulse_i = 1'b1;
        repeat (4) @(negedge clk);
        vpulse_i = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < NLAT; i++) exp_out[i] = exp_sh[i];
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) exp_out[i] = '0;
        for (int i = 0; i < NLAT; i++) exp_sh[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1");

        // R7: one-cycle visibility of a live register
        do_start(); do_byte(ADDR_WR); do_byte(8'h07);
        do_byte(8'hA5); model_write(7, 8'hA5);
        check_reg(7, 8'hA5, "R7");
        do_stop();

        // R3/R4/R5/R6/R8 sweep over every index and both modes
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 32; s++) begin
                logic [7:0] sub;
                sub = {m[0], 2'b00, s[4:0]};
                do_start(); do_byte(ADDR_WR); do_byte(sub);
                for (int k = 0; k < 3; k++) begin
                    logic [7:0] d;
                    d = 8'(s * 7 + k * 29 + m * 101 + 1);
                    do_byte(d);
                    model_write(m ? s : s + k, d);
                end
                do_stop();
                check_all(m ? "R5_R6_R8" : "R4_R6_R8");
                do_vpulse();
                check_all(m ? "R5_R8" : "R4_R8");
            end
        end

        // R3: bits 6:5 ignored
        do_start(); do_byte(ADDR_WR); do_byte(8'h6A);
        do_byte(8'h3C); model_write(10, 8'h3C); do_stop();
        check_all("R3");

        // R2: wrong address and read direction
        do_start(); do_byte(8'h5A); do_byte(8'h0B); do_byte(8'hEE); do_stop();
        check_all("R2");
        do_start(); do_byte(ADDR_WR | 8'h01); do_byte(8'h0B); do_byte(8'hEE); do_stop();
        check_all("R2");

        // R10: ends after sub-address, stray bytes after stop, repeated start
        do_start(); do_byte(ADDR_WR); do_byte(8'h0C); do_stop();
        do_byte(8'h99); do_byte(8'h98);
        check_all("R10");
        do_start(); do_byte(ADDR_WR); do_byte(8'h0D); do_byte(8'h44); model_write(13, 8'h44);
        do_start(); do_byte(ADDR_WR); do_byte(8'h0E); do_stop();
        check_all("R10");

        // R10: byte coincident with start is ignored
        @(negedge clk); start_i = 1'b1; byte_valid_i = 1'b1; byte_i = ADDR_WR;
        @(negedge clk); start_i = 1'b0; byte_valid_i = 1'b0;
        do_byte(8'h05); do_byte(8'h77); do_stop();
        check_all("R10");

        // R9: held-high vertical input
        do_start(); do_byte(ADDR_WR); do_byte(8'h00); do_byte(8'h11);
        model_write(0, 8'h11); do_stop();
        @(negedge clk); vpulse_i = 1'b1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < NLAT; i++) exp_out[i] = exp_sh[i];
        check_all("R9");
        do_start(); do_byte(ADDR_WR); do_byte(8'h80); do_byte(8'h22); do_byte(8'h33);
        model_write(0, 8'h33); do_stop();
        repeat (5) @(negedge clk);
        check_reg(0, 8'h11, "R9");
        vpulse_i = 1'b0;
        repeat (5) @(negedge clk);
        check_reg(0, 8'h11, "R9");
        vpulse_i = 1'b1;
        repeat (3) @(negedge clk);
        check_reg(0, 8'h33, "R9");
        vpulse_i = 1'b0;
        repeat (3) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule